// File: doc/BRIEF.md
# Threshold-Ready UART Transmitter

This block turns bytes into asynchronous serial frames on a single output line. Characters are written into a 16-entry queue, one per strobe. A serializer takes them out in order and shifts each one out at the rate of an external bit tick. The frame layout is set by control inputs: the character length, an optional parity bit with odd or even sense, and one or two stop bits. The serializer samples these settings when it takes a character, so the frame in progress keeps its layout.

Software learns when it may write through a ready flag. The flag is not tied to an empty queue. It tracks whether the queue level is at or below a 4-bit programmable threshold. Two action strobes force the flag high or low, and the forced value holds until the level next crosses the threshold. Two further controls act on the line. A break control holds the line low for as long as it is set. With flow control enabled, an active-low clear-to-send input must be low before a new frame may begin.

Top module: `uart_tx_thr`

## Requirements
- R1: After reset, txd is high, fifo_count is 0 and tx_ready is 1.
- R2: A frame is one low start bit followed by data_bits+1 data bits, least significant first, and then the stop bits (high). A new frame begins only at a bit_tick. Each later bit_tick moves the line to the next bit, so every bit lasts one tick period. After the last stop bit the line stays idle for one further tick period before the next frame starts.
- R3: When par_en is 1, a parity bit follows the data. If par_even is 1, the data bits and the parity bit hold an even number of ones. If par_even is 0, they hold an odd number.
- R4: When two_stop is 1 the frame ends with two stop bits; otherwise it ends with one. The spacing between the starts of back-to-back frames is therefore (data_bits+1 + par_en + stops + 2) tick periods.
- R5: Characters are sent in the order they were written. fifo_count is the number of characters queued and not yet taken by the serializer. It is updated at the clock edge that samples the write, and it can reach 16.
- R6: A write while fifo_count is 16 is ignored: the count does not change and the byte is not queued.
- R7: fifo_clr empties the queue, so fifo_count is 0 after the clock edge that samples it. A write in the same cycle is discarded.
- R8: When the condition fifo_count <= thr changes value, tx_ready takes the new value one clock after the change in count.
- R9: rdy_set sets tx_ready and rdy_clr clears it, one clock after the strobe. If both are high, the clear wins. A forced value holds until the next change of the threshold condition.
- R10: While force_brk is 1, txd is low whatever the queue or serializer state.
- R11: With hs_en 1 and cts_n high, no new frame starts. A frame already started runs to its end. With hs_en 0, cts_n has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for one character |
| wr_data | input | 8 | Character to queue |
| data_bits | input | 3 | Character length minus one |
| par_en | input | 1 | Send a parity bit |
| par_even | input | 1 | 1 selects even parity, 0 odd |
| two_stop | input | 1 | 1 selects two stop bits |
| hs_en | input | 1 | Enable clear-to-send gating |
| force_brk | input | 1 | Hold txd low |
| thr | input | 4 | Ready threshold on the queue level |
| fifo_clr | input | 1 | Empty the queue |
| rdy_set | input | 1 | Force tx_ready high |
| rdy_clr | input | 1 | Force tx_ready low |
| cts_n | input | 1 | Clear to send, active low |
| bit_tick | input | 1 | One-cycle strobe per bit period |
| txd | output | 1 | Serial output, idle high |
| tx_ready | output | 1 | Ready flag |
| fifo_count | output | 5 | Characters waiting in the queue |

## Verification
The bench measures the exact spacing of back-to-back frames. A design that miscounted data, parity or stop bits, or that dropped the idle slot, would shift the second start edge. It walks the queue level through the threshold one write at a time. A flag that used < instead of <=, or that lagged by the wrong number of cycles, would show the wrong value at 10 or 11 characters. It writes to a full queue and clears while writing, where a design without the full guard would wrap the count and one with the wrong priority would keep a character. It drops clear-to-send during a frame: a design that aborted the frame would corrupt the received byte, and one that ignored the gate would start the next frame early.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [2:0] {
    TX_IDLE,
    TX_START,
    TX_DATA,
    TX_PAR,
    TX_STOP
  } tx_state_e;
endpackage

// File: rtl/tx_fifo.sv
module tx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push,
  input  logic [DW-1:0]              din,
  input  logic                       pop,
  output logic [DW-1:0]              dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign push_ok = push && !clr && (cnt_q != CW'(DEPTH));
  assign pop_ok  = pop && !clr && (cnt_q != '0);

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (clr) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_ok) wp_d = nxt(wp_q);
      if (pop_ok)  rp_d = nxt(rp_q);
      cnt_d = cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wp_q] <= din;
  end

  assign dout  = mem_q[rp_q];
  assign count = cnt_q;
  assign empty = (cnt_q == '0);

  // R6
  full_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !clr && cnt_q == CW'(DEPTH)) |=> (cnt_q == CW'(DEPTH)));

  // R7
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

  // R5
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/tx_serializer.sv
module tx_serializer import uart_tx_pkg::*; #(
  parameter int DW = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bit_tick,
  input  logic                   empty,
  input  logic                   hs_en,
  input  logic                   cts_n,
  input  logic [DW-1:0]          din,
  input  logic [$clog2(DW)-1:0]  data_bits,
  input  logic                   par_en,
  input  logic                   par_even,
  input  logic                   two_stop,
  output logic                   pop,
  output logic                   line
);
  localparam int BW = $clog2(DW);

  tx_state_e     state_q, state_d;
  logic [DW-1:0] sh_q, sh_d, mask;
  logic [BW-1:0] left_q, left_d;
  logic          par_q, par_d, pen_q, pen_d, stop2_q, stop2_d;
  logic          go;

  assign mask = {DW{1'b1}} >> (BW'(DW-1) - data_bits);
  assign go   = bit_tick && !empty && (!hs_en || !cts_n);

  always_comb begin
    state_d = state_q;
    sh_d    = sh_q;
    left_d  = left_q;
    par_d   = par_q;
    pen_d   = pen_q;
    stop2_d = stop2_q;
    pop     = 1'b0;
    case (state_q)
      TX_IDLE: if (go) begin
        pop     = 1'b1;
        sh_d    = din & mask;
        left_d  = data_bits;
        par_d   = (^(din & mask)) ^ ~par_even;
        pen_d   = par_en;
        stop2_d = two_stop;
        state_d = TX_START;
      end
      TX_START: if (bit_tick) state_d = TX_DATA;
      TX_DATA: if (bit_tick) begin
        sh_d = sh_q >> 1;
        if (left_q == '0) state_d = pen_q ? TX_PAR : TX_STOP;
        else              left_d  = left_q - 1'b1;
      end
      TX_PAR: if (bit_tick) state_d = TX_STOP;
      TX_STOP: if (bit_tick) begin
        if (stop2_q) stop2_d = 1'b0;
        else         state_d = TX_IDLE;
      end
      default: state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      sh_q    <= '0;
      left_q  <= '0;
      par_q   <= 1'b0;
      pen_q   <= 1'b0;
      stop2_q <= 1'b0;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      left_q  <= left_d;
      par_q   <= par_d;
      pen_q   <= pen_d;
      stop2_q <= stop2_d;
    end
  end

  always_comb begin
    case (state_q)
      TX_START: line = 1'b0;
      TX_DATA:  line = sh_q[0];
      TX_PAR:   line = par_q;
      default:  line = 1'b1;
    endcase
  end

  // R11
  cts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TX_IDLE && hs_en && cts_n) |=> (state_q == TX_IDLE));

  // R2
  start_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q != TX_IDLE) |-> $past(bit_tick));
endmodule

// File: rtl/uart_tx_thr.sv
module uart_tx_thr #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [DW-1:0]              wr_data,
  input  logic [$clog2(DW)-1:0]      data_bits,
  input  logic                       par_en,
  input  logic                       par_even,
  input  logic                       two_stop,
  input  logic                       hs_en,
  input  logic                       force_brk,
  input  logic [$clog2(DEPTH)-1:0]   thr,
  input  logic                       fifo_clr,
  input  logic                       rdy_set,
  input  logic                       rdy_clr,
  input  logic                       cts_n,
  input  logic                       bit_tick,
  output logic                       txd,
  output logic                       tx_ready,
  output logic [$clog2(DEPTH+1)-1:0] fifo_count
);
  localparam int CW = $clog2(DEPTH+1);

  logic [1:0]    rs_q;
  logic          rst_s_n;
  logic          empty, pop, line;
  logic [DW-1:0] head;
  logic          lvl_ok, lvl_q, rdy_q, rdy_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  tx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_s_n), .clr(fifo_clr), .push(wr_en), .din(wr_data),
    .pop(pop), .dout(head), .count(fifo_count), .empty(empty)
  );

  tx_serializer #(.DW(DW)) u_ser (
    .clk(clk), .rst_n(rst_s_n), .bit_tick(bit_tick), .empty(empty),
    .hs_en(hs_en), .cts_n(cts_n), .din(head), .data_bits(data_bits),
    .par_en(par_en), .par_even(par_even), .two_stop(two_stop),
    .pop(pop), .line(line)
  );

  assign lvl_ok = (fifo_count <= CW'(thr));

  always_comb begin
    rdy_d = rdy_q;
    if (lvl_ok != lvl_q) rdy_d = lvl_ok;
    if (rdy_set)         rdy_d = 1'b1;
    if (rdy_clr)         rdy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      lvl_q <= 1'b1;
      rdy_q <= 1'b1;
    end else begin
      lvl_q <= lvl_ok;
      rdy_q <= rdy_d;
    end
  end

  assign tx_ready = rdy_q;
  assign txd      = force_brk ? 1'b0 : line;

  // R9
  ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    rdy_clr |=> !tx_ready);

  // R9
  ready_set_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rdy_set && !rdy_clr) |=> tx_ready);
endmodule

// File: tb/sim_uart_tx_thr.sv
module sim_uart_tx_thr;
  localparam int CLK_PERIOD = 10;
  localparam int TICK = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, par_en, par_even, two_stop, hs_en, force_brk;
  logic fifo_clr, rdy_set, rdy_clr, cts_n, bit_tick;
  logic [7:0] wr_data;
  logic [2:0] data_bits;
  logic [3:0] thr;
  logic txd, tx_ready;
  logic [4:0] fifo_count;
  int checks = 0, failures = 0, cyc = 0;

  uart_tx_thr u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .data_bits(data_bits), .par_en(par_en), .par_even(par_even),
    .two_stop(two_stop), .hs_en(hs_en), .force_brk(force_brk), .thr(thr),
    .fifo_clr(fifo_clr), .rdy_set(rdy_set), .rdy_clr(rdy_clr), .cts_n(cts_n),
    .bit_tick(bit_tick), .txd(txd), .tx_ready(tx_ready), .fifo_count(fifo_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    bit_tick = 1'b0;
    forever begin
      repeat (TICK-1) @(negedge clk);
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_start(output int t);
    int n = 0;
    while (txd !== 1'b0 && n < 600) begin @(negedge clk); n++; end
    chk(n < 600, "R2", "start bit seen", n, 0);
    t = cyc;
  endtask

  task automatic rx_body(input int nb, input bit pe, input bit pev, input bit two, output logic [7:0] d);
    logic p;
    d = '0;
    repeat (3) @(negedge clk);
    chk(txd === 1'b0, "R2", "start bit level", txd, 0);
    for (int i = 0; i < nb; i++) begin
      repeat (TICK) @(negedge clk);
      d[i] = txd;
    end
    if (pe) begin
      repeat (TICK) @(negedge clk);
      p = txd;
      chk(p === (pev ? ^d : ~^d), "R3", "parity bit", p, pev ? ^d : ~^d);
    end
    repeat (TICK) @(negedge clk);
    chk(txd === 1'b1, "R2", "stop bit level", txd, 1);
    if (two) begin
      repeat (TICK) @(negedge clk);
      chk(txd === 1'b1, "R4", "second stop level", txd, 1);
    end
  endtask

  task automatic t_reset;
    chk(txd === 1'b1, "R1", "txd after reset", txd, 1);
    chk(fifo_count == 0, "R1", "count after reset", fifo_count, 0);
    chk(tx_ready === 1'b1, "R1", "ready after reset", tx_ready, 1);
  endtask

  task automatic t_frame(input logic [7:0] v, input int nb, input bit pe, input bit pev, input bit two);
    int t0, t1;
    logic [7:0] got, exp;
    exp = v & 8'((1 << nb) - 1);
    data_bits = 3'(nb - 1); par_en = pe; par_even = pev; two_stop = two;
    hs_en = 1'b0;
    push(v);
    push(v);
    wait_start(t0);
    rx_body(nb, pe, pev, two, got);
    chk(got == exp, "R2", "first frame data", got, exp);
    wait_start(t1);
    chk(t1 - t0 == (nb + pe + (two ? 2 : 1) + 2) * TICK, "R4", "frame spacing",
        t1 - t0, (nb + pe + (two ? 2 : 1) + 2) * TICK);
    rx_body(nb, pe, pev, two, got);
    chk(got == exp, "R3", "second frame data", got, exp);
  endtask

  task automatic t_order;
    int t;
    logic [7:0] got;
    data_bits = 3'd7; par_en = 1'b0; two_stop = 1'b0; hs_en = 1'b0;
    push(8'h11); push(8'h22); push(8'h33);
    for (int i = 1; i <= 3; i++) begin
      wait_start(t);
      rx_body(8, 1'b0, 1'b0, 1'b0, got);
      chk(got == 8'(i * 8'h11), "R5", "write order", got, i * 8'h11);
    end
  endtask

  task automatic t_level;
    hs_en = 1'b1; cts_n = 1'b1; thr = 4'd10;
    fifo_clr = 1'b1; @(negedge clk); fifo_clr = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 10; i++) push(8'(i));
    chk(fifo_count == 10, "R5", "count at 10", fifo_count, 10);
    @(negedge clk);
    chk(tx_ready === 1'b1, "R8", "ready at threshold", tx_ready, 1);
    push(8'hAA);
    chk(tx_ready === 1'b1, "R8", "ready lags count", tx_ready, 1);
    @(negedge clk);
    chk(tx_ready === 1'b0, "R8", "ready above threshold", tx_ready, 0);
    rdy_set = 1'b1; @(negedge clk); rdy_set = 1'b0;
    chk(tx_ready === 1'b1, "R9", "forced set", tx_ready, 1);
    repeat (5) @(negedge clk);
    chk(tx_ready === 1'b1, "R9", "forced set holds", tx_ready, 1);
    rdy_clr = 1'b1; @(negedge clk); rdy_clr = 1'b0;
    chk(tx_ready === 1'b0, "R9", "forced clear", tx_ready, 0);
    rdy_set = 1'b1; @(negedge clk); rdy_set = 1'b0;
    rdy_set = 1'b1; rdy_clr = 1'b1; @(negedge clk); rdy_set = 1'b0; rdy_clr = 1'b0;
    chk(tx_ready === 1'b0, "R9", "clear wins over set", tx_ready, 0);
    for (int i = 0; i < 5; i++) push(8'hB0);
    chk(fifo_count == 16, "R5", "count reaches 16", fifo_count, 16);
    push(8'hEE);
    chk(fifo_count == 16, "R6", "write when full", fifo_count, 16);
    chk(txd === 1'b1, "R11", "no frame while cts high", txd, 1);
    fifo_clr = 1'b1; wr_en = 1'b1; wr_data = 8'h77;
    @(negedge clk);
    fifo_clr = 1'b0; wr_en = 1'b0;
    chk(fifo_count == 0, "R7", "clear beats write", fifo_count, 0);
    @(negedge clk);
    chk(tx_ready === 1'b1, "R8", "ready after level returns", tx_ready, 1);
  endtask

  task automatic t_break;
    force_brk = 1'b1; @(negedge clk);
    chk(txd === 1'b0, "R10", "break low", txd, 0);
    repeat (20) @(negedge clk);
    chk(txd === 1'b0, "R10", "break holds", txd, 0);
    force_brk = 1'b0; @(negedge clk);
    chk(txd === 1'b1, "R10", "release to idle", txd, 1);
  endtask

  task automatic t_handshake;
    int t;
    logic [7:0] got;
    data_bits = 3'd7; par_en = 1'b0; two_stop = 1'b0;
    hs_en = 1'b1; cts_n = 1'b1;
    push(8'h3C); push(8'hC3);
    repeat (40) @(negedge clk);
    chk(txd === 1'b1 && fifo_count == 2, "R11", "held by cts", fifo_count, 2);
    cts_n = 1'b0;
    wait_start(t);
    cts_n = 1'b1;
    rx_body(8, 1'b0, 1'b0, 1'b0, got);
    chk(got == 8'h3C, "R11", "frame completes after cts rises", got, 8'h3C);
    repeat (40) @(negedge clk);
    chk(txd === 1'b1 && fifo_count == 1, "R11", "next frame held", fifo_count, 1);
    hs_en = 1'b0;
    wait_start(t);
    rx_body(8, 1'b0, 1'b0, 1'b0, got);
    chk(got == 8'hC3, "R11", "cts ignored when disabled", got, 8'hC3);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; data_bits = 3'd7;
    par_en = 1'b0; par_even = 1'b0; two_stop = 1'b0; hs_en = 1'b0;
    force_brk = 1'b0; thr = 4'd0; fifo_clr = 1'b0; rdy_set = 1'b0;
    rdy_clr = 1'b0; cts_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_frame(8'hA5, 8, 1'b0, 1'b0, 1'b0);
    t_frame(8'h5B, 7, 1'b1, 1'b1, 1'b0);
    t_frame(8'hC4, 8, 1'b1, 1'b0, 1'b1);
    t_frame(8'h13, 5, 1'b0, 1'b0, 1'b1);
    t_order();
    t_level();
    t_break();
    t_handshake();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule